// File: doc/BRIEF.md
# ATA PIO Register Access Controller

This block runs single register reads and writes on a parallel ATA device bus, as the host. A local agent gives it one request: a two-bit chip-select choice, a 3-bit register address, a direction flag and 16-bit write data. The block then steps the bus through its phases: address setup, strobe, an optional device-requested wait, address hold and recovery. It returns the read data and a one-clock completion pulse.

Every phase length is a parameter counted in clock cycles. The device can stretch a cycle by pulling the ready line low. The ready line passes through a two-flop synchronizer, and the block checks it once, at a fixed point inside the strobe. If the device is not ready at that point, the strobe stays asserted until ready returns, or until a timeout ends the cycle and flags an error.

Top module: `ata_pio_regctl`

## Requirements
- R1: After reset the bus is idle: `ide_cs_n` = 2'b11, `ide_rd_n` = `ide_wr_n` = 1, `ide_doe` = 0, `rsp_done` = 0, `rsp_err` = 0 and `rsp_rdata` = 0.
- R2: A request is accepted at the clock edge where `req_valid` is high in idle. For the whole cycle, `ide_cs_n` = ~`req_sel` and `ide_da` = `req_addr`, starting T_SETUP clocks before the strobe falls and ending T_HOLD clocks after the strobe rises; at all other times `ide_cs_n` = 2'b11. A write pulses only `ide_wr_n` and a read pulses only `ide_rd_n`.
- R3: Strobe cycles are numbered from 0. The block checks ready in strobe cycle T_CHECK-1. Because of the synchronizer, that check sees the value `ide_iordy` had in strobe cycle T_CHECK-3. If that value is high, the strobe lasts exactly T_STROBE clocks; this includes a ready dip that ends before that cycle.
- R4: If ready is low at the check, the strobe stays low. It ends after the first strobe cycle j, with j ≥ T_STROBE-1, in which the synchronized ready (the `ide_iordy` value of cycle j-2) is high.
- R5: On a read, `ide_din` is captured in the last strobe cycle. It appears on `rsp_rdata` with `rsp_done` and holds until the next read completes.
- R6: On a write, `ide_doe` is high and `ide_dout` = `req_wdata` from the first setup clock through the last hold clock. `ide_doe` is low at all other times, and always during reads.
- R7: After the hold, the bus is deselected for T_RECOV clocks. `rsp_done` then pulses for one clock, T_SETUP+W+T_HOLD+T_RECOV+1 clocks after acceptance, where W is the strobe width.
- R8: If ready is still low in strobe cycle T_CHECK+T_TIMEOUT-1, the strobe ends after that cycle, so W = T_CHECK+T_TIMEOUT. `rsp_err` = 1 is then reported together with `rsp_done`.
- R9: `req_valid` has no effect while a cycle is in progress. No second bus cycle follows.
- R10: `rsp_err` is 0 on every cycle that ends without a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start strobe, taken only in idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Chip-select choice, active high |
| req_addr | input | 3 | Device register address |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Last read data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Ready timeout, valid with rsp_done |
| ide_cs_n | output | 2 | Active-low chip selects |
| ide_da | output | 3 | Device address lines |
| ide_rd_n | output | 1 | Active-low read strobe |
| ide_wr_n | output | 1 | Active-low write strobe |
| ide_dout | output | 16 | Data bus output value |
| ide_doe | output | 1 | Data bus output enable |
| ide_din | input | 16 | Data bus input value |
| ide_iordy | input | 1 | Device ready, low requests a wait |

## Verification
A wrong phase state or counter value shows up within the same bus cycle. The strobe falls at the wrong clock, the strobe is too wide or too narrow, or the select lines drop early, and `rsp_done` then lands on the wrong clock. A wrong wait decision changes the strobe width, and the bench can tell a short ready dip from a real stretch. Stale capture or a wrongly latched timeout shows on `rsp_rdata` or `rsp_err` at the completion pulse. A start that was not ignored shows as a second select within a few clocks.

// File: rtl/ata_pio_regctl.sv
module ata_pio_regctl #(
  parameter int T_SETUP   = 2,
  parameter int T_STROBE  = 8,
  parameter int T_CHECK   = 4,
  parameter int T_HOLD    = 2,
  parameter int T_RECOV   = 3,
  parameter int T_TIMEOUT = 40,
  parameter int DW        = 16,
  parameter int AW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_sel,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [1:0]    ide_cs_n,
  output logic [AW-1:0] ide_da,
  output logic          ide_rd_n,
  output logic          ide_wr_n,
  output logic [DW-1:0] ide_dout,
  output logic          ide_doe,
  input  logic [DW-1:0] ide_din,
  input  logic          ide_iordy
);
  localparam int LIMIT = T_SETUP + T_STROBE + T_HOLD + T_RECOV + T_CHECK + T_TIMEOUT;
  localparam int CW    = $clog2(LIMIT + 1);

  typedef enum logic [2:0] {IDLE, SETUP, STROBE, WAIT, HOLD, RECOV} phase_t;

  phase_t        st;
  logic [CW-1:0] cnt;
  logic [1:0]    rdy_sync;
  logic          wr_q, to_q;
  logic [1:0]    sel_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  wire rdy    = rdy_sync[1];
  wire active = (st == SETUP) || (st == STROBE) || (st == WAIT) || (st == HOLD);
  wire strobe = (st == STROBE) || (st == WAIT);

  assign ide_cs_n = active ? ~sel_q : 2'b11;
  assign ide_da   = active ? addr_q : '0;
  assign ide_rd_n = !(strobe && !wr_q);
  assign ide_wr_n = !(strobe && wr_q);
  assign ide_doe  = active && wr_q;
  assign ide_dout = wdata_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdy_sync <= 2'b11;
    else        rdy_sync <= {rdy_sync[0], ide_iordy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      to_q      <= 1'b0;
      sel_q     <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_rdata <= '0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          st      <= SETUP;
          cnt     <= '0;
          wr_q    <= req_write;
          sel_q   <= req_sel;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          to_q    <= 1'b0;
        end
        SETUP:
          if (cnt == CW'(T_SETUP - 1)) begin st <= STROBE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        STROBE:
          if (cnt == CW'(T_CHECK - 1) && !rdy) begin
            st  <= WAIT;
            cnt <= cnt + 1'b1;
          end else if (cnt == CW'(T_STROBE - 1)) begin
            st  <= HOLD;
            cnt <= '0;
            if (!wr_q) rsp_rdata <= ide_din;
          end else cnt <= cnt + 1'b1;
        WAIT:
          if (rdy && cnt >= CW'(T_STROBE - 1)) begin
            st  <= HOLD;
            cnt <= '0;
            if (!wr_q) rsp_rdata <= ide_din;
          end else if (!rdy && cnt == CW'(T_CHECK + T_TIMEOUT - 1)) begin
            st   <= HOLD;
            cnt  <= '0;
            to_q <= 1'b1;
          end else cnt <= cnt + 1'b1;
        HOLD:
          if (cnt == CW'(T_HOLD - 1)) begin st <= RECOV; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        RECOV:
          if (cnt == CW'(T_RECOV - 1)) begin
            st       <= IDLE;
            cnt      <= '0;
            rsp_done <= 1'b1;
            rsp_err  <= to_q;
          end else cnt <= cnt + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_pio_regctl_chk.sv
module ata_pio_regctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rsp_done,
  input logic        rsp_err,
  input logic [1:0]  ide_cs_n,
  input logic [2:0]  ide_da,
  input logic        ide_rd_n,
  input logic        ide_wr_n,
  input logic [15:0] ide_dout,
  input logic        ide_doe
);
  wire strb = !(ide_rd_n && ide_wr_n);

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_rd_n && !ide_wr_n));
  p_addr_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb) |-> $past(ide_cs_n != 2'b11));
  p_addr_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && $past(strb)) |-> ($stable(ide_cs_n) && $stable(ide_da)));
  p_no_drive_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_rd_n |-> !ide_doe);
  p_dout_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_doe && $past(ide_doe)) |-> $stable(ide_dout));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (ide_cs_n == 2'b11 && !strb));
  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done);
endmodule

bind ata_pio_regctl ata_pio_regctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_done(rsp_done), .rsp_err(rsp_err),
  .ide_cs_n(ide_cs_n), .ide_da(ide_da), .ide_rd_n(ide_rd_n),
  .ide_wr_n(ide_wr_n), .ide_dout(ide_dout), .ide_doe(ide_doe)
);

// File: tb/sim_ata_pio_regctl.sv
module sim_ata_pio_regctl;
  localparam int T_SETUP = 2, T_STROBE = 8, T_CHECK = 4, T_HOLD = 2, T_RECOV = 3, T_TIMEOUT = 40;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_sel = 0;
  logic [2:0] req_addr = 0;
  logic [15:0] req_wdata = 0, ide_din = 0;
  logic ide_iordy = 1;
  logic [15:0] rsp_rdata, ide_dout;
  logic rsp_done, rsp_err, ide_rd_n, ide_wr_n, ide_doe;
  logic [1:0] ide_cs_n;
  logic [2:0] ide_da;
  int vectors = 0, fails = 0;

  always #5 clk = ~clk;

  ata_pio_regctl #(.T_SETUP(T_SETUP), .T_STROBE(T_STROBE), .T_CHECK(T_CHECK),
    .T_HOLD(T_HOLD), .T_RECOV(T_RECOV), .T_TIMEOUT(T_TIMEOUT), .DW(16), .AW(3)) u0 (
    .clk, .rst_n, .req_valid, .req_write, .req_sel, .req_addr, .req_wdata,
    .rsp_rdata, .rsp_done, .rsp_err, .ide_cs_n, .ide_da, .ide_rd_n, .ide_wr_n,
    .ide_dout, .ide_doe, .ide_din, .ide_iordy);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit raw_rdy(input int i, input int ls, input int le);
    return !(i >= 0 && i >= ls && i < le);
  endfunction

  function automatic int exp_width(input int ls, input int le, output bit to);
    to = 0;
    if (raw_rdy(T_CHECK - 3, ls, le)) return T_STROBE;
    for (int j = T_CHECK; j < T_CHECK + T_TIMEOUT; j++) begin
      if (raw_rdy(j - 2, ls, le) && j >= T_STROBE - 1) return j + 1;
      if (!raw_rdy(j - 2, ls, le) && j == T_CHECK + T_TIMEOUT - 1) begin
        to = 1;
        return j + 1;
      end
    end
    to = 1;
    return T_CHECK + T_TIMEOUT;
  endfunction

  task automatic run_txn(input bit wr, input logic [1:0] sel, input logic [2:0] addr,
                         input logic [15:0] wd, input logic [15:0] rv,
                         input int ls, input int le, input int inject_k);
    bit to;
    int w, fall_k, low_cnt, done_k, bad_addr, bad_doe, bad_kind, err_seen, rd_seen, act_end;
    w = exp_width(ls, le, to);
    act_end = T_SETUP + w + T_HOLD;
    fall_k = -1; low_cnt = 0; done_k = -1; bad_addr = 0; bad_doe = 0; bad_kind = 0;
    err_seen = 0; rd_seen = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_sel = sel; req_addr = addr; req_wdata = wd;
    for (int k = 1; k <= 400 && done_k < 0; k++) begin
      int j;
      @(negedge clk);
      req_valid = (k == inject_k);
      req_write = !wr; req_sel = ~sel; req_addr = ~addr; req_wdata = ~wd;
      if (!ide_rd_n || !ide_wr_n) begin
        low_cnt++;
        if (fall_k < 0) fall_k = k;
        if (wr ? !ide_rd_n : !ide_wr_n) bad_kind++;
      end
      if (k <= act_end) begin
        if (ide_cs_n !== ~sel || ide_da !== addr) bad_addr++;
      end else if (ide_cs_n !== 2'b11) bad_addr++;
      if (ide_doe !== (wr && k <= act_end)) bad_doe++;
      else if (ide_doe && ide_dout !== wd) bad_doe++;
      if (rsp_done) begin done_k = k; err_seen = rsp_err; rd_seen = rsp_rdata; end
      j = k - T_SETUP - 1;
      ide_iordy = raw_rdy(j, ls, le);
      ide_din = (j >= le - 1) ? rv : 16'($urandom);
    end
    req_valid = 0; ide_iordy = 1;
    chk(fall_k == T_SETUP + 1, "R2", "strobe fall clock", fall_k, T_SETUP + 1);
    chk(bad_addr == 0 && bad_kind == 0, "R2", "select/address/strobe kind errors", bad_addr + bad_kind, 0);
    if (to) chk(low_cnt == w, "R8", "timeout strobe width", low_cnt, w);
    else if (!raw_rdy(T_CHECK - 3, ls, le)) chk(low_cnt == w, "R4", "stretched strobe width", low_cnt, w);
    else chk(low_cnt == w, "R3", "nominal strobe width", low_cnt, w);
    chk(bad_doe == 0, "R6", "write drive errors", bad_doe, 0);
    chk(done_k == act_end + T_RECOV + 1, "R7", "done clock", done_k, act_end + T_RECOV + 1);
    if (to) chk(err_seen == 1, "R8", "timeout error flag", err_seen, 1);
    else chk(err_seen == 0, "R10", "error flag", err_seen, 0);
    if (!wr && !to) begin
      chk(rd_seen == int'(rv), "R5", "read data at done", rd_seen, rv);
      @(negedge clk);
      chk(rsp_rdata == rv, "R5", "read data held", rsp_rdata, rv);
    end
    if (inject_k > 0) begin
      int extra = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (ide_cs_n !== 2'b11 || rsp_done) extra++;
      end
      chk(extra == 0, "R9", "activity after busy start", extra, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4177));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ide_cs_n == 2'b11 && ide_rd_n && ide_wr_n, "R1", "idle bus lines", {ide_cs_n, ide_rd_n, ide_wr_n}, 15);
    chk(!ide_doe && !rsp_done && !rsp_err && rsp_rdata == 0, "R1", "idle outputs", {ide_doe, rsp_done, rsp_err}, 0);
    run_txn(1, 2'b01, 3'd7, 16'h00a5, 16'h0, 0, 0, 0);
    run_txn(0, 2'b10, 3'd1, 16'h0, 16'h003c, 0, 0, 0);
    run_txn(0, 2'b01, 3'd2, 16'h0, 16'h0081, 0, 1, 0);
    run_txn(0, 2'b01, 3'd3, 16'h0, 16'h00e7, 0, 2, 0);
    run_txn(0, 2'b10, 3'd4, 16'h0, 16'h0042, 0, 15, 0);
    run_txn(1, 2'b10, 3'd5, 16'h1234, 16'h0, 0, 12, 3);
    run_txn(0, 2'b01, 3'd6, 16'h0, 16'h0055, 0, 1000, 0);
    run_txn(0, 2'b01, 3'd0, 16'h0, 16'h0099, 0, 0, 5);
    for (int n = 0; n < 40; n++) begin
      int pat = $urandom % 3;
      int le = (pat == 0) ? 0 : (pat == 1) ? 1 : 2 + ($urandom % 20);
      int inj = ($urandom % 4 == 0) ? 2 + ($urandom % 5) : 0;
      logic [1:0] s = ($urandom % 2) ? 2'b01 : 2'b10;
      run_txn(1'($urandom), s, 3'($urandom), 16'($urandom), {8'h0, 8'($urandom)}, 0, le, inj);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule